// File: doc/BRIEF.md
# Three-Plane SRAM Frame Buffer Controller

This block keeps one 24-bit colour image in three external asynchronous SRAMs. Each SRAM holds one colour plane. All three share a single address bus, so the red, green and blue bytes of a pixel sit at the same address. The block reads the image back as a continuous raster and presents it to the parallel input of a DVI transmitter, together with data enable and horizontal and vertical sync. A host processor loads new pixels through an SPI slave port, and the block writes them into the SRAMs only in blanking positions.

Time is divided into two-cycle slots, and each slot is one raster position. A slot holds either one read, one write or nothing. An active position always reads. A blanking position writes the oldest queued host pixel if one is waiting. Each SRAM is a 16-bit-wide part used as byte storage: the pixel index is split into a word address and a byte-lane select.

Top module: `fbc_top`

## Requirements
- R1: While `rst_n` is low, `sram_oe_n`, `sram_we_n`, `sram_ub_n` and `sram_lb_n` are high, and `sram_dq_oe`, `dvi_de`, `dvi_hs` and `dvi_vs` are low. `sram_ce_n` is low at all times.
- R2: The raster has `H_ACT+H_FP+H_SYNC+H_BP` positions per line and `V_ACT+V_FP+V_SYNC+V_BP` lines, and each position lasts two clock cycles. At a position with column h and line v:
  - `dvi_de` is high exactly when h < H_ACT and v < V_ACT.
  - `dvi_hs` is high exactly when H_ACT+H_FP <= h < H_ACT+H_FP+H_SYNC.
  - `dvi_vs` is high exactly on lines with V_ACT+V_FP <= v < V_ACT+V_FP+V_SYNC.
- R3: While `dvi_de` is high, `dvi_rgb` is the pixel stored for that position, with red on bits 23:16, green on bits 15:8 and blue on bits 7:0.
- R4: The pixel index is v*H_ACT+h. The word address is the index shifted right by one bit. Index bit 0 equal to 0 selects the lower byte (`sram_lb_n` low). Index bit 0 equal to 1 selects the upper byte (`sram_ub_n` low). The red SRAM uses data bits 23:16, the green SRAM bits 15:8 and the blue SRAM bits 7:0. In every access exactly one byte enable is low.
- R5: A read keeps the address stable and `sram_oe_n` low for two cycles, and captures the data at the end of the second cycle.
- R6: `sram_dq_oe` is high only while `sram_we_n` is low. `sram_oe_n` and `sram_we_n` are never low together. The write address is set up one cycle before `sram_we_n` falls.
- R7: SRAM writes occur only in blanking positions, and every active position is read.
- R8: SPI uses mode 0 (data sampled on rising SCLK, MSB first, while `spi_cs_n` is low). The first 24 bits of a frame are the start pixel index. Each following 24-bit group is one pixel {R,G,B}, written at the current index, after which the index increments by one.
- R9: Raising `spi_cs_n` discards a partly received pixel. The next frame starts again with a start index.
- R10: After `rst_n` rises, `dvi_de` first goes high right after the sixth rising clock edge, showing position (0,0).
- R11: In blanking positions `dvi_rgb` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from the host |
| sram_addr | output | 20 | Word address shared by all three SRAMs |
| sram_ce_n | output | 1 | Chip enable, held active |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_ub_n | output | 1 | Upper byte enable, active low |
| sram_lb_n | output | 1 | Lower byte enable, active low |
| sram_dq_o | output | 24 | Write data for the red, green and blue SRAMs |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_i | input | 24 | Read data from the red, green and blue SRAMs |
| dvi_rgb | output | 24 | Pixel to the transmitter |
| dvi_de | output | 1 | Data enable |
| dvi_hs | output | 1 | Horizontal sync, active high |
| dvi_vs | output | 1 | Vertical sync, active high |

## Verification
The read slot for a raster position runs two cycles before that position appears at the DVI outputs. The first visible pixel follows the sixth edge after reset release. The bench therefore aligns its raster model to the first rise of `dvi_de`, checks the sixth-edge timing separately, and at every falling edge compares the outputs with the position (cycle count / 2). For the SRAM pins at that same falling edge, it uses the next position. SPI pixels reach the SRAM only at a later blanking slot, so the bench waits two full frames after a frame ends before it compares pixels or inspects its SRAM arrays. The SRAM model returns a junk byte unless the address and output enable have been held for a full previous cycle, which catches an early data capture.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam int ADDR_W = 20;
  localparam int IDX_W  = ADDR_W + 1;
  localparam int CH_W   = 8;
  localparam int PIX_W  = 3 * CH_W;
  localparam int WORD_W = 24;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_RD   = 2'd1,
    SLOT_WR   = 2'd2
  } slot_kind_e;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [PIX_W-1:0] rgb;
  } wr_req_t;
endpackage

// File: rtl/fbc_raster.sv
module fbc_raster
  import fbc_pkg::*;
#(
  parameter int H_ACT  = 8,
  parameter int H_FP   = 2,
  parameter int H_SYNC = 2,
  parameter int H_BP   = 2,
  parameter int V_ACT  = 4,
  parameter int V_FP   = 1,
  parameter int V_SYNC = 1,
  parameter int V_BP   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic             nxt_active,
  output logic             nxt_hs,
  output logic             nxt_vs,
  output logic [IDX_W-1:0] nxt_idx
);
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HW = $clog2(H_TOT + 1);
  localparam int VW = $clog2(V_TOT + 1);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);
  localparam logic [HW-1:0] H_ACT_L = HW'(H_ACT);
  localparam logic [VW-1:0] V_ACT_L = VW'(V_ACT);
  localparam logic [HW-1:0] HS_BEG = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] HS_END = HW'(H_ACT + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_BEG = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] VS_END = VW'(V_ACT + V_FP + V_SYNC);

  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;

  always_comb begin
    h_d = h_q;
    v_d = v_q;
    if (adv) begin
      if (h_q == H_LAST) begin
        h_d = '0;
        v_d = (v_q == V_LAST) ? '0 : v_q + 1'b1;
      end else begin
        h_d = h_q + 1'b1;
      end
    end
  end

  // start on the last position so the first slot after reset is blank
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= H_LAST;
      v_q <= V_LAST;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  always_comb begin
    nxt_active = (h_d < H_ACT_L) && (v_d < V_ACT_L);
    nxt_hs     = (h_d >= HS_BEG) && (h_d < HS_END);
    nxt_vs     = (v_d >= VS_BEG) && (v_d < VS_END);
    nxt_idx    = IDX_W'(v_d) * IDX_W'(H_ACT) + IDX_W'(h_d);
  end

  assert_h_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_q <= H_LAST) && (v_q <= V_LAST));

  assert_line_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && h_q == H_LAST) |=> (h_q == '0));
endmodule

// File: rtl/fbc_spi_rx.sv
module fbc_spi_rx
  import fbc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    spi_sclk,
  input  logic    spi_cs_n,
  input  logic    spi_mosi,
  output logic    push,
  output wr_req_t push_req
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [2:0] sclk_s;
  logic [1:0] cs_s;
  logic [1:0] mosi_s;
  logic       rise;
  logic       sel;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              hdr_q, hdr_d;
  logic [IDX_W-1:0]  idx_q, idx_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], spi_sclk};
      cs_s   <= {cs_s[0], spi_cs_n};
      mosi_s <= {mosi_s[0], spi_mosi};
    end
  end

  assign rise = sclk_s[1] & ~sclk_s[2];
  assign sel  = ~cs_s[1];

  always_comb begin
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    hdr_d    = hdr_q;
    idx_d    = idx_q;
    push     = 1'b0;
    push_req = '{idx: idx_q, rgb: sh_q};
    if (!sel) begin
      cnt_d = '0;
      hdr_d = 1'b0;
    end else if (rise) begin
      sh_d = {sh_q[WORD_W-2:0], mosi_s[1]};
      if (cnt_q == CNT_LAST) begin
        cnt_d = '0;
        if (!hdr_q) begin
          hdr_d = 1'b1;
          idx_d = sh_d[IDX_W-1:0];
        end else begin
          push     = 1'b1;
          push_req = '{idx: idx_q, rgb: sh_d};
          idx_d    = idx_q + 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      hdr_q <= 1'b0;
      idx_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      hdr_q <= hdr_d;
      idx_q <= idx_d;
    end
  end

  assert_bitcnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);

  assert_deselect_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (cnt_q == '0) && !hdr_q);
endmodule

// File: rtl/fbc_wfifo.sv
module fbc_wfifo
  import fbc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  wr_req_t push_req,
  input  logic    pop,
  output logic    empty,
  output wr_req_t head
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W:0]   CNT_FULL = (PTR_W+1)'(DEPTH);

  wr_req_t          mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [PTR_W:0]   cnt_q, cnt_d;
  logic             full;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CNT_FULL);
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    if (!do_push && do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_req;
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/fbc_top.sv
module fbc_top
  import fbc_pkg::*;
#(
  parameter int H_ACT      = 8,
  parameter int H_FP       = 2,
  parameter int H_SYNC     = 2,
  parameter int H_BP       = 2,
  parameter int V_ACT      = 4,
  parameter int V_FP       = 1,
  parameter int V_SYNC     = 1,
  parameter int V_BP       = 1,
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sclk,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic [19:0] sram_addr,
  output logic        sram_ce_n,
  output logic        sram_oe_n,
  output logic        sram_we_n,
  output logic        sram_ub_n,
  output logic        sram_lb_n,
  output logic [23:0] sram_dq_o,
  output logic        sram_dq_oe,
  input  logic [23:0] sram_dq_i,
  output logic [23:0] dvi_rgb,
  output logic        dvi_de,
  output logic        dvi_hs,
  output logic        dvi_vs
);
  logic rst_meta, rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i_n  <= rst_meta;
    end
  end

  logic             phase_q;
  logic             slot_end;
  logic             nxt_active, nxt_hs, nxt_vs;
  logic [IDX_W-1:0] nxt_idx;
  logic             push, pop, fifo_empty;
  wr_req_t          push_req, head;

  assign slot_end = phase_q;

  fbc_raster #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_raster (
    .clk(clk), .rst_n(rst_i_n), .adv(slot_end),
    .nxt_active(nxt_active), .nxt_hs(nxt_hs), .nxt_vs(nxt_vs), .nxt_idx(nxt_idx)
  );

  fbc_spi_rx u_spi (
    .clk(clk), .rst_n(rst_i_n),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .push(push), .push_req(push_req)
  );

  fbc_wfifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_i_n),
    .push(push), .push_req(push_req), .pop(pop),
    .empty(fifo_empty), .head(head)
  );

  slot_kind_e        kind_q, kind_d;
  logic              shs_q, shs_d, svs_q, svs_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              ub_n_q, ub_n_d, lb_n_q, lb_n_d;
  logic              oe_n_q, oe_n_d, we_n_q, we_n_d, dqoe_q, dqoe_d;
  logic [PIX_W-1:0]  wdat_q, wdat_d;
  logic [PIX_W-1:0]  rgb_q, rgb_d;
  logic              de_q, de_d, hs_q, hs_d, vs_q, vs_d;

  always_comb begin
    kind_d = kind_q;  shs_d  = shs_q;  svs_d  = svs_q;
    addr_d = addr_q;  ub_n_d = ub_n_q; lb_n_d = lb_n_q;
    oe_n_d = oe_n_q;  we_n_d = we_n_q; dqoe_d = dqoe_q;
    wdat_d = wdat_q;  rgb_d  = rgb_q;
    de_d   = de_q;    hs_d   = hs_q;   vs_d   = vs_q;
    pop    = 1'b0;
    if (slot_end) begin
      // retire the finished slot to the display side
      rgb_d  = (kind_q == SLOT_RD) ? sram_dq_i : '0;
      de_d   = (kind_q == SLOT_RD);
      hs_d   = shs_q;
      vs_d   = svs_q;
      // open the next slot
      shs_d  = nxt_hs;
      svs_d  = nxt_vs;
      we_n_d = 1'b1;
      dqoe_d = 1'b0;
      if (nxt_active) begin
        kind_d = SLOT_RD;
        addr_d = nxt_idx[IDX_W-1:1];
        ub_n_d = ~nxt_idx[0];
        lb_n_d = nxt_idx[0];
        oe_n_d = 1'b0;
      end else if (!fifo_empty) begin
        kind_d = SLOT_WR;
        pop    = 1'b1;
        addr_d = head.idx[IDX_W-1:1];
        ub_n_d = ~head.idx[0];
        lb_n_d = head.idx[0];
        wdat_d = head.rgb;
        oe_n_d = 1'b1;
      end else begin
        kind_d = SLOT_IDLE;
        ub_n_d = 1'b1;
        lb_n_d = 1'b1;
        oe_n_d = 1'b1;
      end
    end else if (kind_q == SLOT_WR) begin
      we_n_d = 1'b0;
      dqoe_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      phase_q <= 1'b0;
      kind_q  <= SLOT_IDLE;
      shs_q   <= 1'b0;
      svs_q   <= 1'b0;
      addr_q  <= '0;
      ub_n_q  <= 1'b1;
      lb_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dqoe_q  <= 1'b0;
      wdat_q  <= '0;
      rgb_q   <= '0;
      de_q    <= 1'b0;
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
    end else begin
      phase_q <= ~phase_q;
      kind_q  <= kind_d;
      shs_q   <= shs_d;
      svs_q   <= svs_d;
      addr_q  <= addr_d;
      ub_n_q  <= ub_n_d;
      lb_n_q  <= lb_n_d;
      oe_n_q  <= oe_n_d;
      we_n_q  <= we_n_d;
      dqoe_q  <= dqoe_d;
      wdat_q  <= wdat_d;
      rgb_q   <= rgb_d;
      de_q    <= de_d;
      hs_q    <= hs_d;
      vs_q    <= vs_d;
    end
  end

  assign sram_addr  = addr_q;
  assign sram_ce_n  = 1'b0;
  assign sram_oe_n  = oe_n_q;
  assign sram_we_n  = we_n_q;
  assign sram_ub_n  = ub_n_q;
  assign sram_lb_n  = lb_n_q;
  assign sram_dq_o  = wdat_q;
  assign sram_dq_oe = dqoe_q;
  assign dvi_rgb    = rgb_q;
  assign dvi_de     = de_q;
  assign dvi_hs     = hs_q;
  assign dvi_vs     = vs_q;

  assert_oe_we_excl_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(!sram_oe_n && !sram_we_n));

  assert_wr_addr_setup_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(sram_we_n) |-> $stable(sram_addr) && $stable(sram_ub_n) && $stable(sram_lb_n));

  assert_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!sram_oe_n || !sram_we_n) |-> ($countones({sram_ub_n, sram_lb_n}) == 1));

  assert_read_hold_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!sram_oe_n && phase_q) |-> $stable(sram_addr) && $past(!sram_oe_n));

  assert_out_slot_rate_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    !$stable({dvi_de, dvi_hs, dvi_vs}) |-> !phase_q);

  assert_blank_black_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !dvi_de |-> (dvi_rgb == '0));
endmodule

// File: tb/fbc_top_bench.sv
module fbc_top_bench;
  localparam int H_ACT = 8, H_FP = 2, H_SYNC = 2, H_BP = 2;
  localparam int V_ACT = 4, V_FP = 1, V_SYNC = 1, V_BP = 1;
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int FRAME = H_TOT * V_TOT;
  localparam int NPIX  = H_ACT * V_ACT;
  localparam int HALF  = 6;

  logic        clk, rst_n, spi_sclk, spi_cs_n, spi_mosi;
  logic [19:0] sram_addr;
  logic        sram_ce_n, sram_oe_n, sram_we_n, sram_ub_n, sram_lb_n;
  logic [23:0] sram_dq_o, sram_dq_i, dvi_rgb;
  logic        sram_dq_oe, dvi_de, dvi_hs, dvi_vs;

  fbc_top u_fbc_top (
    .clk(clk), .rst_n(rst_n),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i),
    .dvi_rgb(dvi_rgb), .dvi_de(dvi_de), .dvi_hs(dvi_hs), .dvi_vs(dvi_vs)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural SRAM planes: plane c on data bits [8c+7:8c]
  logic [15:0] mem [0:2][0:63];
  logic [19:0] addr_prev;
  logic        oe_prev;
  logic [23:0] exp_img [0:NPIX-1];

  always @(posedge clk) begin
    addr_prev <= sram_addr;
    oe_prev   <= !sram_oe_n;
    if (!sram_we_n) begin
      for (int c = 0; c < 3; c++) begin
        if (!sram_ub_n) mem[c][sram_addr[5:0]][15:8] <= sram_dq_o[8*c +: 8];
        if (!sram_lb_n) mem[c][sram_addr[5:0]][7:0]  <= sram_dq_o[8*c +: 8];
      end
    end
  end

  always_comb begin
    for (int c = 0; c < 3; c++) begin
      if (!sram_oe_n && oe_prev && addr_prev == sram_addr)
        sram_dq_i[8*c +: 8] = !sram_ub_n ? mem[c][sram_addr[5:0]][15:8]
                                         : mem[c][sram_addr[5:0]][7:0];
      else
        sram_dq_i[8*c +: 8] = 8'hEE;
    end
  end

  // raster model aligned to the first rise of dvi_de
  bit started = 0;
  bit chk_on  = 0;
  bit run_on  = 0;
  int ncyc    = 0;

  function automatic bit pos_active(input int p);
    return ((p % H_TOT) < H_ACT) && ((p / H_TOT) < V_ACT);
  endfunction

  always @(negedge clk) begin
    if (run_on) begin
      if (!started && dvi_de) begin
        started = 1;
        ncyc = 0;
      end else if (started) begin
        ncyc++;
      end
      // R6: bus protocol on every cycle
      chk("R6", {31'd0, (!sram_oe_n && !sram_we_n)}, 32'd0, "oe and we both low");
      chk("R6", {31'd0, sram_dq_oe}, {31'd0, !sram_we_n}, "drive only during we pulse");
      if (!sram_oe_n || !sram_we_n)
        chk("R4", {31'd0, sram_ub_n ^ sram_lb_n}, 32'd1, "one byte lane enabled");
      chk("R1", {31'd0, sram_ce_n}, 32'd0, "chip enable held");
      if (started) begin
        int ps;
        ps = ((ncyc / 2) + 1) % FRAME;
        if (!sram_we_n)
          chk("R7", {31'd0, pos_active(ps)}, 32'd0, "write in active slot");
        if (pos_active(ps)) begin
          int pi;
          pi = (ps / H_TOT) * H_ACT + (ps % H_TOT);
          chk("R7", {31'd0, sram_oe_n}, 32'd0, "active slot reads");
          chk("R4", {12'd0, sram_addr}, pi / 2, "word address");
          chk("R4", {30'd0, sram_ub_n, sram_lb_n}, (pi % 2) ? 32'd1 : 32'd2, "lane select");
        end
      end
      if (started && chk_on) begin
        int p, h, v;
        bit de;
        p  = (ncyc / 2) % FRAME;
        h  = p % H_TOT;
        v  = p / H_TOT;
        de = pos_active(p);
        chk("R2", {31'd0, dvi_de}, {31'd0, de}, "data enable");
        chk("R2", {31'd0, dvi_hs}, (h >= H_ACT + H_FP && h < H_ACT + H_FP + H_SYNC) ? 1 : 0, "hsync");
        chk("R2", {31'd0, dvi_vs}, (v >= V_ACT + V_FP && v < V_ACT + V_FP + V_SYNC) ? 1 : 0, "vsync");
        if (de) chk("R3", {8'd0, dvi_rgb}, {8'd0, exp_img[v * H_ACT + h]}, "pixel value");
        else    chk("R11", {8'd0, dvi_rgb}, 32'd0, "blank pixel");
      end
    end
  end

  function automatic logic [23:0] pix_fn(input int seed, input int k);
    return {8'(seed * 7 + k * 3), 8'(k * 11 + seed), 8'(255 - k - seed)};
  endfunction

  task automatic spi_bits(input logic [23:0] w, input int nbits);
    for (int b = 23; b > 23 - nbits; b--) begin
      spi_mosi = w[b];
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic spi_frame(input int start, input int n, input int seed);
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_bits(24'(start), 24);
    for (int k = 0; k < n; k++) begin
      spi_bits(pix_fn(seed, k), 24);
      if (start + k < NPIX) exp_img[start + k] = pix_fn(seed, k);
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic check_frames(input int n);
    repeat (4 * FRAME) @(negedge clk);
    chk_on = 1;
    repeat (2 * FRAME * n) @(negedge clk);
    chk_on = 0;
  endtask

  task automatic check_planes();
    for (int i = 0; i < NPIX; i++) begin
      logic [15:0] wr, wg, wb;
      wr = mem[2][i / 2];
      wg = mem[1][i / 2];
      wb = mem[0][i / 2];
      if (i % 2)
        chk("R4", {8'd0, wr[15:8], wg[15:8], wb[15:8]}, {8'd0, exp_img[i]}, "upper lane content");
      else
        chk("R4", {8'd0, wr[7:0], wg[7:0], wb[7:0]}, {8'd0, exp_img[i]}, "lower lane content");
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int c = 0; c < 3; c++)
      for (int a = 0; a < 64; a++) mem[c][a] = 16'h0000;
    for (int i = 0; i < NPIX; i++) exp_img[i] = 24'h0;
    rst_n = 1'b0;
    spi_sclk = 1'b0;
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    repeat (4) @(negedge clk);
    // R1: quiet bus and outputs while in reset
    chk("R1", {31'd0, sram_oe_n}, 32'd1, "oe_n in reset");
    chk("R1", {31'd0, sram_we_n}, 32'd1, "we_n in reset");
    chk("R1", {30'd0, sram_ub_n, sram_lb_n}, 32'd3, "byte enables in reset");
    chk("R1", {31'd0, sram_dq_oe}, 32'd0, "dq_oe in reset");
    chk("R1", {29'd0, dvi_de, dvi_hs, dvi_vs}, 32'd0, "dvi controls in reset");
    chk("R1", {31'd0, sram_ce_n}, 32'd0, "ce_n in reset");
    rst_n = 1'b1;
    run_on = 1;
    // R10: first data enable after the sixth edge
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk("R10", {31'd0, dvi_de}, (k == 6) ? 32'd1 : 32'd0, "first de timing");
    end
    chk("R10", {8'd0, dvi_rgb}, 32'd0, "first pixel from cleared memory");
    // blank memory: raster shape and black pixels
    check_frames(1);
    // R8: full image from index 0
    spi_frame(0, NPIX, 1);
    check_frames(2);
    check_planes();
    // R8/R4: odd start index lands in the upper lane first
    spi_frame(13, 6, 2);
    check_frames(1);
    check_planes();
    // R9: a broken pixel is dropped and the next frame re-reads a start index
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_bits(24'd5, 24);
    spi_bits(pix_fn(3, 0), 24);
    exp_img[5] = pix_fn(3, 0);
    spi_bits(24'hA5A5A5, 12);
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
    spi_frame(6, 1, 4);
    check_frames(1);
    check_planes();
    chk("R9", {8'd0, exp_img[7]}, {8'd0, pix_fn(1, 7)}, "neighbour untouched (model)");
    finish_run();
  end
endmodule